// File: doc/BRIEF.md
# Bit-Oriented Message Transceiver

This block carries short, repeating code words over the slow overhead data link of a T1 framer. The link runs at 4 kbit/s. A bit-clock enable strobe marks each bit time. On the transmit side the block sends a 16-bit frame over and over. The frame is eight ones, then a zero, then a six-bit code from a programmable input sent most significant bit first, then a closing zero.

On the receive side a hunting state machine looks for eight ones followed by a zero. It then collects the next eight bits, starting with that zero, as a candidate message byte. A persistence filter keeps a short history of match flags against the current candidate. The receive register is written only when the candidate has matched in enough of the recent positions. Writing a message that differs from the stored one sets a sticky flag, and the flag drives an interrupt through a mask input.

Transmit state machine:
- `TX_IDLE`: the link is released, with `tx_active` low and `tx_bit` high.
- `TX_SEND`: the frame is sent.
- The transition `TX_IDLE`→`TX_SEND` happens on `en` high.
- The transition `TX_SEND`→`TX_IDLE` happens on `en` low.

Receive state machine:
- `RX_HUNT`: counts consecutive ones, saturating at eight.
- `RX_BYTE`: shifts in the candidate byte.
- The transition `RX_HUNT`→`RX_BYTE` happens on a zero that arrives after eight ones.
- The transition `RX_BYTE`→`RX_HUNT` happens on the eighth byte bit.

Top module: `bomx_link`

## Requirements
- R1: While sending, `tx_bit` presents frame position p (0..15) and moves to the next position on each `bit_stb`. It holds its value between strobes. Positions 0–7 are 1 and position 8 is 0. Positions 9–14 carry `tx_code[5]` down to `tx_code[0]`. Position 15 is 0, and after it the frame wraps to position 0.
- R2: The code is captured at the start of each frame, meaning while disabled or at the wrap from position 15. A change of `tx_code` in the middle of a frame first appears in the following frame.
- R3: The cycle after `en` falls, `tx_active` is 0 and `tx_bit` is 1, and strobes have no effect. The cycle after `en` rises, `tx_active` is 1 and sending restarts at position 0.
- R4: The receiver aligns only on eight consecutive ones followed by a zero, and shorter runs of ones are discarded. The candidate byte starts with that zero and is assembled most significant bit first.
- R5: A candidate whose last bit is 1 is recorded as a non-match in the history.
- R6: A framed byte is loaded into `rx_msg` once at least 7 of the last 10 recorded positions matched it. A framed byte that differs from the current candidate becomes the new candidate and restarts the history.
- R7: After reset `rx_msg` is 8'hFF, and it holds the last accepted message.
- R8: Loading a message different from `rx_msg` sets `msg_flag`. Accepting the message already held sets nothing.
- R9: A one-cycle `irq_clr` pulse clears `msg_flag`.
- R10: `irq` equals `msg_flag` gated by `irq_mask`, so a low mask suppresses the interrupt but keeps the flag.
- R11: A message seen in fewer than 7 positions leaves `rx_msg` and `msg_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Enables message sending |
| bit_stb | input | 1 | One-cycle pulse per data-link bit time |
| tx_code | input | 6 | Code bits placed inside the sent byte |
| tx_bit | output | 1 | Serial data-link output |
| tx_active | output | 1 | High while the block drives the link |
| rx_bit | input | 1 | Serial data-link input, sampled on `bit_stb` |
| rx_msg | output | 8 | Last accepted message byte |
| irq_mask | input | 1 | 1 lets the flag reach `irq` |
| irq_clr | input | 1 | Write-one-to-clear pulse for the flag |
| msg_flag | output | 1 | Sticky new-message flag |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with its default parameters: a six-bit code, a ten-entry history and a threshold of seven. With these values, the exact sequences of hits and misses at the edge of the threshold can be sent by hand. The first case is six hits that are rejected. The second is seven hits mixed with two misses that are accepted. The third is four misses that push one hit out of the window. With the short window, a candidate restart mid-run can also be forced and then shown to need a full seven fresh hits.

// File: rtl/bomx_pkg.sv
`timescale 1ns/1ps
package bomx_pkg;
    localparam int unsigned PRE_ONES = 8;

    typedef enum logic {
        TX_IDLE,
        TX_SEND
    } tx_state_e;

    typedef enum logic {
        RX_HUNT,
        RX_BYTE
    } rx_state_e;
endpackage

// File: rtl/bomx_tx.sv
`timescale 1ns/1ps
module bomx_tx
    import bomx_pkg::*;
#(
    parameter int unsigned CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              bit_stb,
    input  logic [CODE_W-1:0] code,
    output logic              tx_bit,
    output logic              tx_active
);
    localparam int unsigned FRAME_LEN = PRE_ONES + CODE_W + 2;
    localparam int unsigned CNT_W     = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

    tx_state_e         st, st_nx;
    logic [CNT_W-1:0]  pos;
    logic [CODE_W-1:0] shadow;

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            TX_IDLE: if (en)  st_nx = TX_SEND;
            TX_SEND: if (!en) st_nx = TX_IDLE;
            default:          st_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= st_nx;
    end

    // frame position and code capture at frame start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos    <= '0;
            shadow <= '0;
        end else if (st != TX_SEND || !en) begin
            pos    <= '0;
            shadow <= code;
        end else if (bit_stb) begin
            if (pos == LAST_POS) begin
                pos    <= '0;
                shadow <= code;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        tx_active = (st == TX_SEND);
        tx_bit    = 1'b1;
        if (st == TX_SEND) begin
            if (int'(pos) < int'(PRE_ONES))          tx_bit = 1'b1;
            else if (int'(pos) == int'(PRE_ONES))    tx_bit = 1'b0;
            else if (pos == LAST_POS)                tx_bit = 1'b0;
            else tx_bit = shadow[FRAME_LEN - 2 - int'(pos)];
        end
    end

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_SEND && en && bit_stb && pos != LAST_POS) |=> pos == $past(pos) + 1'b1);
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_SEND && en && !bit_stb) |=> $stable(pos));
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_SEND && en && !bit_stb && pos != '0) |=> $stable(shadow));
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> pos == '0);
endmodule

// File: rtl/bomx_rx_align.sv
`timescale 1ns/1ps
module bomx_rx_align
    import bomx_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              rx_bit,
    output logic              byte_rdy,
    output logic [BYTE_W-1:0] byte_val
);
    localparam int unsigned OW = $clog2(PRE_ONES + 1);
    localparam int unsigned BW = $clog2(BYTE_W + 1);
    localparam logic [OW-1:0] FULL_RUN = OW'(PRE_ONES);
    localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);

    rx_state_e         st, st_nx;
    logic [OW-1:0]     ones;
    logic [BW-1:0]     bcnt;
    logic [BYTE_W-1:0] sr;

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            RX_HUNT: if (bit_stb && !rx_bit && ones == FULL_RUN) st_nx = RX_BYTE;
            RX_BYTE: if (bit_stb && bcnt == LAST_BIT)            st_nx = RX_HUNT;
            default:                                             st_nx = RX_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_HUNT;
        else        st <= st_nx;
    end

    // run counter, byte shifter, ready pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones     <= '0;
            bcnt     <= '0;
            sr       <= '0;
            byte_rdy <= 1'b0;
        end else begin
            byte_rdy <= 1'b0;
            unique case (st)
                RX_HUNT: if (bit_stb) begin
                    if (rx_bit) begin
                        if (ones != FULL_RUN) ones <= ones + 1'b1;
                    end else begin
                        if (ones == FULL_RUN) begin
                            sr   <= '0;
                            bcnt <= BW'(1);
                        end
                        ones <= '0;
                    end
                end
                RX_BYTE: if (bit_stb) begin
                    sr   <= {sr[BYTE_W-2:0], rx_bit};
                    bcnt <= bcnt + 1'b1;
                    ones <= '0;
                    if (bcnt == LAST_BIT) byte_rdy <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign byte_val = sr;

    p_lead_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_rdy |-> !byte_val[BYTE_W-1]);
    p_from_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_rdy |-> $past(st) == RX_BYTE);
    p_rdy_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_rdy |=> !byte_rdy);
endmodule

// File: rtl/bomx_persist.sv
`timescale 1ns/1ps
module bomx_persist #(
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned HIST_LEN = 10,
    parameter int unsigned HIT_MIN  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_rdy,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              irq_clr,
    output logic [BYTE_W-1:0] rx_msg,
    output logic              msg_flag
);
    localparam int unsigned CW = $clog2(HIST_LEN + 1);

    logic [BYTE_W-1:0]   cand;
    logic [HIST_LEN-1:0] hist, hist_nx;
    logic [CW-1:0]       hits;
    logic                framed, same, accept, load;

    always_comb begin
        framed  = !byte_val[0] && !byte_val[BYTE_W-1];
        same    = (byte_val == cand);
        hist_nx = hist;
        if (byte_rdy) begin
            if (!framed)   hist_nx = {hist[HIST_LEN-2:0], 1'b0};
            else if (same) hist_nx = {hist[HIST_LEN-2:0], 1'b1};
            else           hist_nx = HIST_LEN'(1);
        end
        hits = '0;
        for (int i = 0; i < int'(HIST_LEN); i++) hits = hits + CW'(hist_nx[i]);
        accept = byte_rdy && framed && (int'(hits) >= int'(HIT_MIN));
        load   = accept && (byte_val != rx_msg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand     <= '1;
            hist     <= '0;
            rx_msg   <= '1;
            msg_flag <= 1'b0;
        end else begin
            hist <= hist_nx;
            if (byte_rdy && framed) cand <= byte_val;
            if (load) rx_msg <= byte_val;
            if (load)         msg_flag <= 1'b1;
            else if (irq_clr) msg_flag <= 1'b0;
        end
    end

    p_enough_hits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_msg != $past(rx_msg)) |-> $countones(hist) >= HIT_MIN);
    p_framed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_msg != $past(rx_msg)) |-> (!rx_msg[0] && !rx_msg[BYTE_W-1]));
    p_flag_new_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_flag) |-> rx_msg != $past(rx_msg));
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !byte_rdy) |=> !msg_flag);
endmodule

// File: rtl/bomx_link.sv
`timescale 1ns/1ps
module bomx_link #(
    parameter int unsigned CODE_W   = 6,
    parameter int unsigned HIST_LEN = 10,
    parameter int unsigned HIT_MIN  = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                bit_stb,
    input  logic [CODE_W-1:0]   tx_code,
    output logic                tx_bit,
    output logic                tx_active,
    input  logic                rx_bit,
    output logic [CODE_W+1:0]   rx_msg,
    input  logic                irq_mask,
    input  logic                irq_clr,
    output logic                msg_flag,
    output logic                irq
);
    localparam int unsigned BYTE_W = CODE_W + 2;

    logic              byte_rdy;
    logic [BYTE_W-1:0] byte_val;

    bomx_tx #(.CODE_W(CODE_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .bit_stb   (bit_stb),
        .code      (tx_code),
        .tx_bit    (tx_bit),
        .tx_active (tx_active)
    );

    bomx_rx_align #(.BYTE_W(BYTE_W)) u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .rx_bit   (rx_bit),
        .byte_rdy (byte_rdy),
        .byte_val (byte_val)
    );

    bomx_persist #(
        .BYTE_W   (BYTE_W),
        .HIST_LEN (HIST_LEN),
        .HIT_MIN  (HIT_MIN)
    ) u_persist (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_rdy (byte_rdy),
        .byte_val (byte_val),
        .irq_clr  (irq_clr),
        .rx_msg   (rx_msg),
        .msg_flag (msg_flag)
    );

    assign irq = msg_flag & irq_mask;

    p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask && $rose(msg_flag)) |-> irq);
endmodule

// File: tb/test_bomx_link.sv
`timescale 1ns/1ps
module test_bomx_link;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       bit_stb = 1'b0;
    logic [5:0] tx_code = 6'd0;
    logic       tx_bit, tx_active;
    logic       rx_bit = 1'b1;
    logic [7:0] rx_msg;
    logic       irq_mask = 1'b1;
    logic       irq_clr = 1'b0;
    logic       msg_flag, irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    bomx_link i_bomx_link (
        .clk(clk), .rst_n(rst_n), .en(en), .bit_stb(bit_stb), .tx_code(tx_code),
        .tx_bit(tx_bit), .tx_active(tx_active), .rx_bit(rx_bit), .rx_msg(rx_msg),
        .irq_mask(irq_mask), .irq_clr(irq_clr), .msg_flag(msg_flag), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic tx_expect(input int p, input logic [5:0] c);
        if (p < 8)  return 1'b1;
        if (p == 8 || p == 15) return 1'b0;
        return c[14 - p];
    endfunction

    function automatic logic [7:0] wrap(input logic [5:0] c);
        return {1'b0, c, 1'b0};
    endfunction

    task automatic pulse();
        bit_stb = 1'b1;
        tick();
        bit_stb = 1'b0;
        tick();
    endtask

    task automatic rx_push(input logic b);
        rx_bit = b;
        bit_stb = 1'b1;
        tick();
        bit_stb = 1'b0;
        tick();
        tick();
    endtask

    task automatic send_frame(input logic [7:0] m);
        for (int i = 0; i < 8; i++) rx_push(1'b1);
        for (int i = 7; i >= 0; i--) rx_push(m[i]);
    endtask

    task automatic send_n(input logic [7:0] m, input int n);
        for (int i = 0; i < n; i++) send_frame(m);
    endtask

    task automatic clear_flag();
        irq_clr = 1'b1;
        tick();
        irq_clr = 1'b0;
        tick();
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [5:0] c0, c1, cr, prev_c;
        logic [7:0] exp_msg;
        int reps;
        void'($urandom(32'h5EED_0B17));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // reset state
        check("R7 reset rx_msg", rx_msg, 8'hFF);
        check("R8 reset flag", msg_flag, 0);
        check("R10 reset irq", irq, 0);
        check("R3 reset tx_bit", tx_bit, 1);
        check("R3 reset tx_active", tx_active, 0);

        // ---- transmit ----
        c0 = 6'($urandom());
        c1 = ~c0;
        tx_code = c0;
        tick();
        en = 1'b1;
        tick();
        check("R3 active after enable", tx_active, 1);
        for (int p = 0; p < 16; p++) begin
            if (p == 5) tx_code = c1;
            check("R1 R2 frame0 bit", tx_bit, tx_expect(p, c0));
            tick();
            check("R1 hold between strobes", tx_bit, tx_expect(p, c0));
            pulse();
        end
        for (int p = 0; p < 16; p++) begin
            check("R2 frame1 new code", tx_bit, tx_expect(p, c1));
            pulse();
        end
        pulse(); pulse(); pulse();
        en = 1'b0;
        tick();
        check("R3 disabled tx_active", tx_active, 0);
        check("R3 disabled tx_bit", tx_bit, 1);
        pulse(); pulse();
        check("R3 strobe while disabled", tx_bit, 1);
        tx_code = 6'b100101;
        en = 1'b1;
        tick();
        for (int p = 0; p < 16; p++) begin
            check("R3 restart at position 0", tx_bit, tx_expect(p, 6'b100101));
            pulse();
        end
        en = 1'b0;
        tick();

        // ---- receive: threshold ----
        send_n(8'h5A, 6);
        check("R11 six hits no load", rx_msg, 8'hFF);
        check("R11 six hits no flag", msg_flag, 0);
        send_frame(8'h5A);
        check("R6 seventh hit loads", rx_msg, 8'h5A);
        check("R8 flag on new message", msg_flag, 1);
        check("R10 irq with mask high", irq, 1);
        clear_flag();
        check("R9 clear flag", msg_flag, 0);
        check("R9 irq after clear", irq, 0);
        send_n(8'h5A, 7);
        check("R8 same message rx", rx_msg, 8'h5A);
        check("R8 same message no flag", msg_flag, 0);

        // ---- mask ----
        irq_mask = 1'b0;
        send_n(8'h26, 7);
        check("R6 load B", rx_msg, 8'h26);
        check("R10 flag under mask", msg_flag, 1);
        check("R10 irq masked", irq, 0);
        irq_mask = 1'b1;
        tick();
        check("R10 irq unmasked", irq, 1);
        clear_flag();

        // ---- misses inside the window ----
        send_n(8'h4C, 2);
        send_frame(8'h4D);
        send_n(8'h4C, 2);
        send_frame(8'h4D);
        send_n(8'h4C, 2);
        check("R5 six hits two misses no load", rx_msg, 8'h26);
        send_frame(8'h4C);
        check("R5 R6 seven of nine loads", rx_msg, 8'h4C);
        clear_flag();

        // ---- misses pushing a hit out ----
        send_frame(8'h12);
        send_n(8'h13, 4);
        send_n(8'h12, 6);
        check("R5 four misses keep window short", rx_msg, 8'h4C);
        check("R11 no flag when short", msg_flag, 0);
        send_frame(8'h12);
        check("R6 seven of last ten loads", rx_msg, 8'h12);
        clear_flag();

        // ---- candidate restart ----
        send_n(8'h3C, 6);
        send_frame(8'h42);
        send_n(8'h3C, 6);
        check("R6 restart discards old hits", rx_msg, 8'h12);
        send_frame(8'h3C);
        check("R6 seven fresh hits load", rx_msg, 8'h3C);
        clear_flag();

        // ---- alignment ----
        for (int i = 0; i < 5; i++) rx_push(1'b1);
        rx_push(1'b0);
        for (int i = 0; i < 7; i++) rx_push(1'b1);
        rx_push(1'b0);
        rx_push(1'b0);
        send_n(8'h0C, 7);
        check("R4 align and msb first", rx_msg, 8'h0C);
        clear_flag();

        // ---- random runs ----
        exp_msg = rx_msg;
        prev_c = 6'h06;
        for (int it = 0; it < 12; it++) begin
            cr = 6'($urandom());
            if (cr == prev_c) cr = cr + 6'd1;
            prev_c = cr;
            reps = int'($urandom_range(9, 4));
            send_n(wrap(cr), reps);
            if (reps >= 7) begin
                check("R6 random load", rx_msg, wrap(cr));
                check("R8 random flag", msg_flag, (wrap(cr) != exp_msg) ? 1 : 0);
                exp_msg = wrap(cr);
            end else begin
                check("R11 random short run", rx_msg, exp_msg);
                check("R11 random no flag", msg_flag, 0);
            end
            clear_flag();
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule